// File: doc/BRIEF.md
# Flow-Through Synchronous Burst RAM

This block is a single-port synchronous RAM with a built-in two-bit burst sequencer. One registered start address can serve up to four consecutive data cycles. The first cycle uses the loaded address. The next three take their low two address bits from an internal counter, and the upper address bits stay fixed. The counter steps in either linear order (start plus count, modulo four) or interleaved order (start XOR count). A level on `order_lin` picks the order, and that input acts on the address combinationally, with no clock.

Address, control and write controls are registered at each rising edge. Reads are flow-through: the word at the address registered at an edge appears on `rdata` during the cycle that follows, with no output register in between. The write controls sampled at an edge set a byte mask for that cycle. The data on `wdata` is stored into the masked lanes at the next edge. A word is `LANES` lanes of `LANE_W` bits each. Two address strobes start bursts. One, meant for a processor, counts only while the chip enable is low and always makes a read cycle. The other, meant for a cache controller, is always honoured. Chip enable and the two selects are sampled with the strobes. A start with the chip not enabled deselects the block after a single edge. `sleep` acts at once and without a clock: it blanks the output, and edges change nothing while it is high. `oe_n` only gates the output.

Top module: `fts_burst_ram`

## Requirements
- R1: After reset the block is deselected: `rdata_en` is 0 and `rdata` is all zero until a burst is started.
- R2: A read started by a strobe at an edge presents the addressed word on `rdata`, with `rdata_en` 1, in the cycle right after that edge.
- R3: With `order_lin`=1, each edge with `adv_n`=0 and no strobe sets the low two address bits to the previous value plus one modulo 4, and leaves the upper bits unchanged. After the fourth advance the address is back at the start.
- R4: With `order_lin`=0, the burst address low bits are the start low bits XOR a count of 0,1,2,3. From start 2 the order is 2,3,0,1.
- R5: An edge with `adv_n`=1 and no strobe keeps the current burst address.
- R6: A cycle with `gwr_n`=0 writes all lanes with the `wdata` present at the next edge, whatever the values of `bwr_n` and `bsel_n`.
- R7: With `gwr_n`=1 and `bwr_n`=0, only the lanes i whose `bsel_n[i]`=0 are written. Lane i is `wdata[LANE_W*i +: LANE_W]`.
- R8: With `gwr_n`=1 and `bwr_n`=1 the cycle is a read: nothing is written and `rdata_en` is 1.
- R9: `strb_cpu_n`=0 is ignored while `ce_n`=1, and the current burst continues unchanged. While `ce_n`=0, a cycle started by `strb_cpu_n` is a read, and the write controls are ignored.
- R10: A strobe at an edge where the chip is not enabled (`ce_n`=1 with `strb_ctl_n`, or `cs_hi`=0, or `cs_lo_n`=1) makes `rdata_en` 0 from the next cycle on, until an enabled strobe.
- R11: While `sleep`=1, `rdata_en` is 0 at once. Edges change no state and write nothing. After `sleep` falls, the earlier burst state and the array contents are still there.
- R12: `oe_n`=1 forces `rdata_en` to 0 and `rdata` to zero, and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control state |
| addr_i | input | ADDR_W | Burst start address |
| strb_cpu_n | input | 1 | Processor address strobe, active low |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_lin | input | 1 | 1 = linear order, 0 = interleaved order (asynchronous) |
| ce_n | input | 1 | Chip enable, active low |
| cs_hi | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| gwr_n | input | 1 | Global write, active low |
| bwr_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | LANES | Per-lane write selects, active low |
| sleep | input | 1 | Sleep, active high (asynchronous) |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Flow-through read data, zero when not driven |
| rdata_en | output | 1 | Output drive enable (0 stands for high impedance) |

## Verification
The hardest case to reach is a sleep that starts partway through a burst while write strobes keep arriving, followed by a wake that has to resume the same burst address. The stimulus loads a read burst, advances it once, and raises `sleep` between edges. It then drives a controller strobe with a global write and new data across two edges. After `sleep` drops, the bench checks that the burst output is the same word as before. It then reloads the address the write tried to hit and checks that the old contents are still there.

// File: rtl/fts_pkg.sv
package fts_pkg;
    localparam int unsigned CNT_W = 2;

    // low address bits of the current beat from start bits and beat count
    function automatic logic [CNT_W-1:0] burst_low(input logic [CNT_W-1:0] start,
                                                   input logic [CNT_W-1:0] cnt,
                                                   input logic             lin);
        return lin ? (start + cnt) : (start ^ cnt);
    endfunction
endpackage

// File: rtl/fts_burst_seq.sv
module fts_burst_seq
    import fts_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              order_lin,
    output logic [ADDR_W-1:0] cur_addr
);
    always_comb begin
        cur_addr            = base;
        cur_addr[CNT_W-1:0] = burst_low(base[CNT_W-1:0], cnt, order_lin);
    end
endmodule

// File: rtl/fts_wmask_dec.sv
module fts_wmask_dec #(
    parameter int unsigned LANES = 4
) (
    input  logic             gwr_n,
    input  logic             bwr_n,
    input  logic [LANES-1:0] bsel_n,
    output logic [LANES-1:0] mask
);
    always_comb begin
        if (!gwr_n)      mask = '1;
        else if (!bwr_n) mask = ~bsel_n;
        else             mask = '0;
    end
endmodule

// File: rtl/fts_lane_array.sv
module fts_lane_array #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9
) (
    input  logic                     clk,
    input  logic [LANES-1:0]         we,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [LANES*LANE_W-1:0]  wdata,
    output logic [LANES*LANE_W-1:0]  rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[addr];
    end
endmodule

// File: rtl/fts_burst_ram.sv
module fts_burst_ram
    import fts_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic                     strb_cpu_n,
    input  logic                     strb_ctl_n,
    input  logic                     adv_n,
    input  logic                     order_lin,
    input  logic                     ce_n,
    input  logic                     cs_hi,
    input  logic                     cs_lo_n,
    input  logic                     oe_n,
    input  logic                     gwr_n,
    input  logic                     bwr_n,
    input  logic [LANES-1:0]         bsel_n,
    input  logic                     sleep,
    input  logic [LANES*LANE_W-1:0]  wdata,
    output logic [LANES*LANE_W-1:0]  rdata,
    output logic                     rdata_en
);
    localparam int unsigned DATA_W = LANES * LANE_W;

    typedef struct packed {
        logic              sel;
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  cnt;
        logic [LANES-1:0]  wmask;
    } state_t;

    state_t st_d, st_q;

    logic              sel_q;
    logic [LANES-1:0]  wmask_q;
    logic [ADDR_W-1:0] cur_addr;
    logic [LANES-1:0]  dec_mask;
    logic [LANES-1:0]  lane_we;
    logic [DATA_W-1:0] arr_rd;
    logic              enabled;
    logic              cpu_go;
    logic              start;
    logic              commit;

    assign sel_q   = st_q.sel;
    assign wmask_q = st_q.wmask;

    fts_burst_seq #(.ADDR_W(ADDR_W)) seq_i (
        .base      (st_q.base),
        .cnt       (st_q.cnt),
        .order_lin (order_lin),
        .cur_addr  (cur_addr)
    );

    fts_wmask_dec #(.LANES(LANES)) dec_i (
        .gwr_n  (gwr_n),
        .bwr_n  (bwr_n),
        .bsel_n (bsel_n),
        .mask   (dec_mask)
    );

    fts_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) arr_i (
        .clk   (clk),
        .we    (lane_we),
        .addr  (cur_addr),
        .wdata (wdata),
        .rdata (arr_rd)
    );

    always_comb begin
        enabled = !ce_n && cs_hi && !cs_lo_n;
        cpu_go  = !strb_cpu_n && !ce_n;
        start   = cpu_go || !strb_ctl_n;
        commit  = !sleep && st_q.sel && (st_q.wmask != '0);
        lane_we = commit ? st_q.wmask : '0;

        st_d = st_q;
        if (!sleep) begin
            if (start) begin
                if (enabled) begin
                    st_d.sel   = 1'b1;
                    st_d.base  = addr_i;
                    st_d.cnt   = '0;
                    st_d.wmask = cpu_go ? '0 : dec_mask;
                end else begin
                    st_d.sel   = 1'b0;
                    st_d.wmask = '0;
                end
            end else if (st_q.sel) begin
                if (!adv_n) st_d.cnt = st_q.cnt + 1'b1;
                st_d.wmask = dec_mask;
            end else begin
                st_d.wmask = '0;
            end
        end

        rdata_en = !sleep && !oe_n && st_q.sel && (st_q.wmask == '0);
        rdata    = rdata_en ? arr_rd : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/fts_burst_ram_chk.sv
module fts_burst_ram_chk #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strb_cpu_n,
    input logic              strb_ctl_n,
    input logic              adv_n,
    input logic              order_lin,
    input logic              ce_n,
    input logic              cs_hi,
    input logic              cs_lo_n,
    input logic              oe_n,
    input logic              sleep,
    input logic              rdata_en,
    input logic              sel_q,
    input logic [LANES-1:0]  wmask_q,
    input logic [ADDR_W-1:0] cur_addr
);
    logic not_en;
    assign not_en = ce_n || !cs_hi || cs_lo_n;

    assert_sleep_blank_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !rdata_en);

    assert_sleep_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> $stable(sel_q) && $stable(wmask_q) && ($stable(cur_addr) || !$stable(order_lin)));

    assert_oe_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !rdata_en);

    assert_deselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !strb_ctl_n && not_en) |=> !rdata_en);

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && strb_cpu_n && strb_ctl_n && adv_n) |=>
        ($stable(cur_addr) || !$stable(order_lin)));

    assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && strb_cpu_n && strb_ctl_n && !adv_n && sel_q && order_lin) |=>
        (!order_lin ||
         ((cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1) &&
          (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])))));

    assert_cpu_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !strb_cpu_n && ce_n && strb_ctl_n && adv_n) |=>
        $stable(sel_q) && ($stable(cur_addr) || !$stable(order_lin)));

    assert_cpu_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !strb_cpu_n && !ce_n) |=> (wmask_q == '0));
endmodule

bind fts_burst_ram fts_burst_ram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb_cpu_n (strb_cpu_n),
    .strb_ctl_n (strb_ctl_n),
    .adv_n      (adv_n),
    .order_lin  (order_lin),
    .ce_n       (ce_n),
    .cs_hi      (cs_hi),
    .cs_lo_n    (cs_lo_n),
    .oe_n       (oe_n),
    .sleep      (sleep),
    .rdata_en   (rdata_en),
    .sel_q      (sel_q),
    .wmask_q    (wmask_q),
    .cur_addr   (cur_addr)
);

// File: tb/fts_burst_ram_tb_top.sv
module fts_burst_ram_tb_top;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned ADDR_W = 6;
    localparam int unsigned LANES  = 4;
    localparam int unsigned LANE_W = 9;
    localparam int unsigned DATA_W = LANES * LANE_W;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] addr_i;
    logic              strb_cpu_n, strb_ctl_n, adv_n, order_lin;
    logic              ce_n, cs_hi, cs_lo_n, oe_n, gwr_n, bwr_n, sleep;
    logic [LANES-1:0]  bsel_n;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rdata;
    logic              rdata_en;

    logic [DATA_W-1:0] model [1 << ADDR_W];
    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fts_burst_ram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .strb_cpu_n(strb_cpu_n),
        .strb_ctl_n(strb_ctl_n), .adv_n(adv_n), .order_lin(order_lin), .ce_n(ce_n),
        .cs_hi(cs_hi), .cs_lo_n(cs_lo_n), .oe_n(oe_n), .gwr_n(gwr_n), .bwr_n(bwr_n),
        .bsel_n(bsel_n), .sleep(sleep), .wdata(wdata), .rdata(rdata), .rdata_en(rdata_en)
    );

    task automatic chk(input bit ok, input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_rd(input string req, input logic [DATA_W-1:0] exp);
        chk(rdata_en === 1'b1, req, {35'd0, rdata_en}, 36'd1);
        chk(rdata === exp, req, rdata, exp);
    endtask

    // one edge, then sample 2 time units later
    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        strb_cpu_n = 1'b1; strb_ctl_n = 1'b1; adv_n = 1'b1;
        ce_n = 1'b0; cs_hi = 1'b1; cs_lo_n = 1'b0; oe_n = 1'b0;
        gwr_n = 1'b1; bwr_n = 1'b1; bsel_n = '1; sleep = 1'b0;
    endtask

    // global write with byte controls set against it (R6)
    task automatic write_word(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        idle(); strb_ctl_n = 1'b0; addr_i = a; gwr_n = 1'b0; bwr_n = 1'b0; bsel_n = '1;
        cyc();
        idle(); wdata = d;
        cyc();
        model[a] = d;
    endtask

    task automatic load_read(input logic [ADDR_W-1:0] a);
        idle(); strb_ctl_n = 1'b0; addr_i = a;
        cyc();
        idle();
    endtask

    task automatic t_reset();
        chk(rdata_en === 1'b0, "R1 en", {35'd0, rdata_en}, 36'd0);
        chk(rdata === '0, "R1 data", rdata, '0);
    endtask

    task automatic t_fill();
        for (int i = 4; i < 8; i++) write_word(ADDR_W'(i), DATA_W'(36'h1_0000_0000 + 36'h111 * i));
        write_word(6'd20, 36'hA_BCDE_F012);
        chk_rd("R6 gw all lanes", model[20]);
        for (int i = 4; i < 8; i++) begin
            load_read(ADDR_W'(i));
            chk_rd("R2 flow-through read", model[i]);
        end
    endtask

    task automatic t_linear();
        int seq [5] = '{5, 6, 7, 4, 5};
        order_lin = 1'b1;
        load_read(6'd5);
        chk_rd("R3 linear beat0", model[5]);
        for (int i = 1; i < 5; i++) begin
            adv_n = 1'b0;
            cyc();
            chk_rd("R3 linear beat", model[seq[i]]);
        end
        adv_n = 1'b1;
        cyc();
        chk_rd("R5 hold", model[5]);
        cyc();
        chk_rd("R5 hold again", model[5]);
    endtask

    task automatic t_interleave();
        int seq [4] = '{6, 7, 4, 5};
        order_lin = 1'b0;
        load_read(6'd6);
        chk_rd("R4 interleave beat0", model[6]);
        for (int i = 1; i < 4; i++) begin
            adv_n = 1'b0;
            cyc();
            chk_rd("R4 interleave beat", model[seq[i]]);
        end
        order_lin = 1'b1;
    endtask

    task automatic t_byte();
        logic [DATA_W-1:0] nd;
        nd = 36'h5_5555_5555;
        idle(); strb_ctl_n = 1'b0; addr_i = 6'd20; bwr_n = 1'b0; bsel_n = 4'b1010;
        cyc();
        idle(); wdata = nd;
        cyc();
        model[20][0 +: 9]  = nd[0 +: 9];
        model[20][18 +: 9] = nd[18 +: 9];
        chk_rd("R7 byte lanes 0 and 2", model[20]);
        idle(); strb_ctl_n = 1'b0; addr_i = 6'd20; bsel_n = 4'b0000;
        cyc();
        idle(); wdata = 36'hF_FFFF_FFFF;
        chk_rd("R8 read cycle", model[20]);
        cyc();
        chk_rd("R8 nothing written", model[20]);
    endtask

    task automatic t_cpu();
        load_read(6'd4);
        strb_cpu_n = 1'b0; ce_n = 1'b1; addr_i = 6'd7;
        cyc();
        idle();
        chk_rd("R9 cpu strobe ignored", model[4]);
        strb_cpu_n = 1'b0; addr_i = 6'd6; gwr_n = 1'b0;
        cyc();
        idle(); wdata = 36'h0_0000_0BAD;
        chk_rd("R9 cpu read", model[6]);
        cyc();
        chk_rd("R9 cpu no write", model[6]);
    endtask

    task automatic t_desel();
        load_read(6'd7);
        strb_ctl_n = 1'b0; cs_hi = 1'b0;
        cyc();
        idle();
        chk(rdata_en === 1'b0, "R10 cs_hi deselect", {35'd0, rdata_en}, 36'd0);
        adv_n = 1'b0;
        cyc();
        chk(rdata_en === 1'b0, "R10 stays deselected", {35'd0, rdata_en}, 36'd0);
        load_read(6'd5);
        chk_rd("R10 reselect", model[5]);
        strb_ctl_n = 1'b0; cs_lo_n = 1'b1;
        cyc();
        idle();
        chk(rdata_en === 1'b0, "R10 cs_lo_n deselect", {35'd0, rdata_en}, 36'd0);
    endtask

    task automatic t_oe();
        load_read(6'd4);
        oe_n = 1'b1;
        #1;
        chk(rdata_en === 1'b0, "R12 oe off", {35'd0, rdata_en}, 36'd0);
        chk(rdata === '0, "R12 data zero", rdata, '0);
        cyc();
        oe_n = 1'b0;
        #1;
        chk_rd("R12 state kept", model[4]);
    endtask

    task automatic t_sleep();
        load_read(6'd4);
        adv_n = 1'b0;
        cyc();
        idle();
        chk_rd("R11 before sleep", model[5]);
        sleep = 1'b1;
        #1;
        chk(rdata_en === 1'b0, "R11 sleep blank", {35'd0, rdata_en}, 36'd0);
        strb_ctl_n = 1'b0; addr_i = 6'd7; gwr_n = 1'b0; wdata = 36'h0_DEAD_0000;
        cyc();
        strb_ctl_n = 1'b1; adv_n = 1'b0;
        cyc();
        chk(rdata_en === 1'b0, "R11 still blank", {35'd0, rdata_en}, 36'd0);
        idle();
        #1;
        chk_rd("R11 burst resumes", model[5]);
        load_read(6'd7);
        chk_rd("R11 contents kept", model[7]);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        idle();
        order_lin = 1'b1;
        addr_i = '0;
        wdata = '0;
        rst_n = 1'b0;
        #(CLK_PERIOD * 3 + 2);
        t_reset();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_fill();
        t_linear();
        t_interleave();
        t_byte();
        t_cpu();
        t_desel();
        t_oe();
        t_sleep();
        finish_run();
    end
endmodule